// File: doc/BRIEF.md
# Carry and Status Flag Unit

This unit keeps the two condition flags of a small 4-bit processor core: a carry flag and a status flag. Each cycle the instruction decoder raises at most a few one-bit class strobes. The unit turns them into flag updates using the ALU carry-out, the ALU or compare result bit, and, for rotates through carry, the operand being rotated. The status flag drives the branch condition seen by conditional jumps and conditional calls.

On interrupt entry the stack logic saves the flag pair from two dedicated outputs, which always show the current flags. On return from interrupt it sends the saved pair back and raises a restore strobe. An ordinary subroutine return raises no strobe here, so it leaves both flags alone. After any conditional branch the status flag is forced to 1, whether or not the branch was taken.

Top module: `flag_unit`

## Requirements
- R1: While rst_n is low and after it rises, carry_flag is 0 and status_flag is 1, so the first conditional branch is taken.
- R2: An arithmetic strobe (arith_en) loads carry_flag from alu_carry and status_flag from result_bit on the next rising edge.
- R3: A compare strobe (cmp_en) or bit-test strobe (btest_en) loads status_flag from result_bit and leaves carry_flag unchanged.
- R4: A conditional-branch strobe (br_en) sets status_flag to 1 regardless of result_bit and leaves carry_flag unchanged.
- R5: setc_en forces carry_flag to 1 and clrc_en forces it to 0. Neither changes status_flag.
- R6: rotl_en loads carry_flag with rot_operand bit DATA_W-1 and rotr_en loads it with rot_operand bit 0. Neither changes status_flag.
- R7: branch_cond always equals the current status_flag.
- R8: save_carry and save_status always equal the current carry_flag and status_flag.
- R9: rti_en loads carry_flag from restore_carry and status_flag from restore_status on the next rising edge.
- R10: When no strobe is active, as on an ordinary subroutine return, both flags hold their values.
- R11: When several strobes are active together, only the highest one acts. The order, highest first, is rti_en, br_en, arith_en, cmp_en, btest_en, setc_en, clrc_en, rotl_en, rotr_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rti_en | input | 1 | Interrupt return: restore both flags |
| br_en | input | 1 | Conditional branch or conditional call executed |
| arith_en | input | 1 | Arithmetic instruction |
| cmp_en | input | 1 | Compare instruction |
| btest_en | input | 1 | Bit-test instruction |
| setc_en | input | 1 | Set-carry instruction |
| clrc_en | input | 1 | Clear-carry instruction |
| rotl_en | input | 1 | Rotate left through carry |
| rotr_en | input | 1 | Rotate right through carry |
| alu_carry | input | 1 | ALU carry-out (overflow) |
| result_bit | input | 1 | ALU, compare or bit-test result |
| rot_operand | input | DATA_W | Operand of the rotate instruction |
| restore_carry | input | 1 | Saved carry returned from the stack |
| restore_status | input | 1 | Saved status returned from the stack |
| carry_flag | output | 1 | Current carry flag |
| status_flag | output | 1 | Current status flag |
| branch_cond | output | 1 | Condition for conditional branch and call |
| save_carry | output | 1 | Carry presented for saving on interrupt entry |
| save_status | output | 1 | Status presented for saving on interrupt entry |

## Verification
The bench builds the unit with DATA_W = 4 and the default reset values, carry 0 and status 1. With a 4-bit operand the two edge bits that feed a rotate can be set opposite to each other and to the middle bits. An operand such as 1000 or 0001 therefore shows whether a rotate in each direction picks the correct end. Because the reset values differ from each other, a swap of the two flags or a wrong reset constant shows up in the first check.

// File: rtl/flag_unit_pkg.sv
package flag_unit_pkg;

  // Instruction classes, in priority order after CLS_NONE (lower value wins).
  typedef enum logic [3:0] {
    CLS_NONE    = 4'd0,
    CLS_RESTORE = 4'd1,
    CLS_BRANCH  = 4'd2,
    CLS_ARITH   = 4'd3,
    CLS_CMP     = 4'd4,
    CLS_BTEST   = 4'd5,
    CLS_SETC    = 4'd6,
    CLS_CLRC    = 4'd7,
    CLS_ROTL    = 4'd8,
    CLS_ROTR    = 4'd9
  } flag_cls_e;

  localparam int NUM_STROBES = 9;

  typedef struct packed {
    logic carry;
    logic status;
  } flag_pair_t;

endpackage

// File: rtl/flag_cls_sel.sv
module flag_cls_sel
  import flag_unit_pkg::*;
(
  input  logic [NUM_STROBES-1:0] strobes,  // bit 0 = highest priority
  output flag_cls_e              cls
);

  always_comb begin
    cls = CLS_NONE;
    for (int i = NUM_STROBES - 1; i >= 0; i--) begin
      if (strobes[i]) cls = flag_cls_e'(4'(i + 1));
    end
  end

endmodule

// File: rtl/flag_next.sv
module flag_next
  import flag_unit_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  flag_cls_e         cls,
  input  flag_pair_t        cur,
  input  logic              alu_carry,
  input  logic              result_bit,
  input  logic [DATA_W-1:0] rot_operand,
  input  flag_pair_t        restored,
  output flag_pair_t        nxt,
  output logic              upd_carry,
  output logic              upd_status
);

  localparam int MSB = DATA_W - 1;

  // Bit that leaves the operand during a rotate through carry.
  function automatic logic shifted_out(input logic [DATA_W-1:0] v, input logic left);
    return left ? v[MSB] : v[0];
  endfunction

  always_comb begin
    nxt        = cur;
    upd_carry  = 1'b0;
    upd_status = 1'b0;
    unique case (cls)
      CLS_RESTORE: begin
        nxt        = restored;
        upd_carry  = 1'b1;
        upd_status = 1'b1;
      end
      CLS_BRANCH: begin
        nxt.status = 1'b1;
        upd_status = 1'b1;
      end
      CLS_ARITH: begin
        nxt.carry  = alu_carry;
        nxt.status = result_bit;
        upd_carry  = 1'b1;
        upd_status = 1'b1;
      end
      CLS_CMP, CLS_BTEST: begin
        nxt.status = result_bit;
        upd_status = 1'b1;
      end
      CLS_SETC: begin
        nxt.carry = 1'b1;
        upd_carry = 1'b1;
      end
      CLS_CLRC: begin
        nxt.carry = 1'b0;
        upd_carry = 1'b1;
      end
      CLS_ROTL: begin
        nxt.carry = shifted_out(rot_operand, 1'b1);
        upd_carry = 1'b1;
      end
      CLS_ROTR: begin
        nxt.carry = shifted_out(rot_operand, 1'b0);
        upd_carry = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/flag_unit.sv
module flag_unit
  import flag_unit_pkg::*;
#(
  parameter int   DATA_W     = 4,
  parameter logic RST_CARRY  = 1'b0,
  parameter logic RST_STATUS = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rti_en,
  input  logic              br_en,
  input  logic              arith_en,
  input  logic              cmp_en,
  input  logic              btest_en,
  input  logic              setc_en,
  input  logic              clrc_en,
  input  logic              rotl_en,
  input  logic              rotr_en,
  input  logic              alu_carry,
  input  logic              result_bit,
  input  logic [DATA_W-1:0] rot_operand,
  input  logic              restore_carry,
  input  logic              restore_status,
  output logic              carry_flag,
  output logic              status_flag,
  output logic              branch_cond,
  output logic              save_carry,
  output logic              save_status
);

  localparam flag_pair_t RST_PAIR = '{carry: RST_CARRY, status: RST_STATUS};

  logic [NUM_STROBES-1:0] strobes;
  flag_cls_e              sel_cls;
  flag_pair_t             cur_q;
  flag_pair_t             nxt_d;
  flag_pair_t             restored;
  logic                   upd_carry;
  logic                   upd_status;

  // Priority order: bit 0 highest.
  assign strobes  = {rotr_en, rotl_en, clrc_en, setc_en, btest_en,
                     cmp_en, arith_en, br_en, rti_en};
  assign restored = '{carry: restore_carry, status: restore_status};

  flag_cls_sel u_sel (
    .strobes (strobes),
    .cls     (sel_cls)
  );

  flag_next #(.DATA_W(DATA_W)) u_next (
    .cls         (sel_cls),
    .cur         (cur_q),
    .alu_carry   (alu_carry),
    .result_bit  (result_bit),
    .rot_operand (rot_operand),
    .restored    (restored),
    .nxt         (nxt_d),
    .upd_carry   (upd_carry),
    .upd_status  (upd_status)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= RST_PAIR;
    end else begin
      if (upd_carry)  cur_q.carry  <= nxt_d.carry;
      if (upd_status) cur_q.status <= nxt_d.status;
    end
  end

  assign carry_flag  = cur_q.carry;
  assign status_flag = cur_q.status;
  assign branch_cond = cur_q.status;
  assign save_carry  = cur_q.carry;
  assign save_status = cur_q.status;

endmodule

// File: rtl/flag_unit_chk.sv
module flag_unit_chk #(
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rti_en,
  input logic              br_en,
  input logic              arith_en,
  input logic              setc_en,
  input logic              alu_carry,
  input logic              result_bit,
  input logic [DATA_W-1:0] rot_operand,
  input logic              restore_carry,
  input logic              restore_status,
  input logic              carry_flag,
  input logic              status_flag,
  input logic              upd_carry,
  input logic              upd_status
);

  assert_restore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rti_en |=> (carry_flag == $past(restore_carry)) && (status_flag == $past(restore_status)));

  assert_branch_forces_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (br_en && !rti_en) |=> status_flag && (carry_flag == $past(carry_flag)));

  assert_arith_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (arith_en && !rti_en && !br_en) |=>
      (carry_flag == $past(alu_carry)) && (status_flag == $past(result_bit)));

  assert_carry_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_carry |=> $stable(carry_flag));

  assert_status_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_status |=> $stable(status_flag));

  assert_setc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (setc_en && !rti_en && !br_en && !arith_en) |=> carry_flag);

  logic unused_ok;
  assign unused_ok = ^rot_operand;

endmodule

bind flag_unit flag_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/flag_unit_bench.sv
module flag_unit_bench;

  localparam int DATA_W = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic rti_en, br_en, arith_en, cmp_en, btest_en, setc_en, clrc_en, rotl_en, rotr_en;
  logic alu_carry, result_bit, restore_carry, restore_status;
  logic [DATA_W-1:0] rot_operand;
  logic carry_flag, status_flag, branch_cond, save_carry, save_status;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flag_unit #(.DATA_W(DATA_W)) u_flag_unit (.*);

  task automatic clear_inputs();
    {rti_en, br_en, arith_en, cmp_en, btest_en, setc_en, clrc_en, rotl_en, rotr_en} = '0;
    alu_carry = 0; result_bit = 0; restore_carry = 0; restore_status = 0;
    rot_operand = '0;
  endtask

  // Compare carry/status plus the three mirrored outputs (R7, R8).
  task automatic check(input string req, input logic exp_c, input logic exp_s);
    vectors++;
    if (carry_flag !== exp_c || status_flag !== exp_s) begin
      miscompares++;
      $display("FAIL %s: carry/status got %b%b expected %b%b", req, carry_flag, status_flag, exp_c, exp_s);
    end
    if (branch_cond !== status_flag || save_carry !== carry_flag || save_status !== status_flag) begin
      miscompares++;
      $display("FAIL R7/R8 (%s): cond/save got %b%b%b expected %b%b%b", req,
               branch_cond, save_carry, save_status, status_flag, carry_flag, status_flag);
    end
  endtask

  // Strobes are already set; take one edge, then clear them.
  task automatic step();
    @(posedge clk); #1;
    clear_inputs();
  endtask

  task automatic t_reset();
    clear_inputs();
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1 check("R1 in reset", 1'b0, 1'b1);
    rst_n = 1;
    @(posedge clk); #1;
    check("R1 after reset", 1'b0, 1'b1);
  endtask

  task automatic t_arith();
    arith_en = 1; alu_carry = 1; result_bit = 0; step(); check("R2 overflow", 1, 0);
    arith_en = 1; alu_carry = 0; result_bit = 1; step(); check("R2 no overflow", 0, 1);
    arith_en = 1; alu_carry = 1; result_bit = 1; step(); check("R2 both", 1, 1);
  endtask

  task automatic t_cmp_btest();
    cmp_en = 1; result_bit = 0; alu_carry = 0; step(); check("R3 cmp", 1, 0);
    btest_en = 1; result_bit = 1; step(); check("R3 btest", 1, 1);
  endtask

  task automatic t_branch();
    cmp_en = 1; result_bit = 0; step(); check("R3 setup", 1, 0);
    br_en = 1; result_bit = 0; alu_carry = 0; step(); check("R4 branch after 0", 1, 1);
    br_en = 1; step(); check("R4 branch after 1", 1, 1);
  endtask

  task automatic t_setclr();
    clrc_en = 1; step(); check("R5 clear", 0, 1);
    setc_en = 1; step(); check("R5 set", 1, 1);
  endtask

  task automatic t_rotate();
    rotl_en = 1; rot_operand = 4'b0111; step(); check("R6 rotl msb0", 0, 1);
    rotl_en = 1; rot_operand = 4'b1000; step(); check("R6 rotl msb1", 1, 1);
    rotr_en = 1; rot_operand = 4'b1110; step(); check("R6 rotr lsb0", 0, 1);
    rotr_en = 1; rot_operand = 4'b0001; step(); check("R6 rotr lsb1", 1, 1);
  endtask

  task automatic t_restore();
    rti_en = 1; restore_carry = 0; restore_status = 0; step(); check("R9 restore 00", 0, 0);
    rti_en = 1; restore_carry = 1; restore_status = 0; step(); check("R9 restore 10", 1, 0);
  endtask

  task automatic t_idle();
    alu_carry = 0; result_bit = 1; rot_operand = 4'b0000; step(); check("R10 idle", 1, 0);
    step(); check("R10 idle again", 1, 0);
  endtask

  task automatic t_priority();
    rti_en = 1; arith_en = 1; restore_carry = 0; restore_status = 1; alu_carry = 1; result_bit = 0;
    step(); check("R11 restore over arith", 0, 1);
    cmp_en = 1; result_bit = 0; step(); check("R11 setup", 0, 0);
    br_en = 1; arith_en = 1; alu_carry = 1; result_bit = 0;
    step(); check("R11 branch over arith", 0, 1);
    arith_en = 1; setc_en = 1; alu_carry = 0; result_bit = 0;
    step(); check("R11 arith over setc", 0, 0);
    setc_en = 1; clrc_en = 1; step(); check("R11 setc over clrc", 1, 0);
    clrc_en = 1; rotl_en = 1; rot_operand = 4'b1000; step(); check("R11 clrc over rotl", 0, 0);
    rotl_en = 1; rotr_en = 1; rot_operand = 4'b1000; step(); check("R11 rotl over rotr", 1, 0);
    cmp_en = 1; btest_en = 1; setc_en = 1; result_bit = 1; step(); check("R11 cmp over setc", 1, 1);
  endtask

  initial begin
    t_reset();
    t_arith();
    t_cmp_btest();
    t_branch();
    t_setclr();
    t_rotate();
    t_restore();
    t_idle();
    t_priority();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule